// File: doc/BRIEF.md
# Dual-Lane Complex Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate engine for complex samples. Each operand word is 32 bits wide. The low 16 bits hold the real part and the high 16 bits hold the imaginary part, both in signed two's complement. The unit has two identical lanes. Each lane has two 16×16 multipliers, an adder/subtractor and a pair of 40-bit accumulators.

The first lane always produces the real part of the product and the second lane the imaginary part. With both lanes working together, the unit finishes one full complex product per cycle. A conjugate mode instead computes conj(a)·b, which is the form used for correlation.

Every issued operation carries a separate opcode and accumulator selector for each lane, plus one shift amount. The opcode clears and loads, adds, subtracts or reads out the selected accumulator. Whatever the opcode, the lane result port returns the selected accumulator after the operation. The value is shifted arithmetically right by the shift amount and saturated to signed 16 bits. The pipeline has two register stages, so results appear two cycles after issue.

Top module: `cmac_pair`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `res_valid` is 0, and all four accumulators read out as 0.
- R2: With `conj`=0, the value combined in the real lane is `ar*br - ai*bi` and in the imaginary lane is `ar*bi + ai*br`. Here `ar`/`ai` are `a[15:0]`/`a[31:16]` and `br`/`bi` are `b[15:0]`/`b[31:16]`, all signed.
- R3: With `conj`=1, the real lane combines `ar*br + ai*bi` and the imaginary lane combines `ar*bi - ai*br`.
- R4: `res_valid` is 1 exactly two clock cycles after each cycle in which `issue` is 1, and 0 otherwise.
- R5: The lane opcode encoding is: 2'b00 clears the selected accumulator and loads the combined value, 2'b01 adds the combined value to it, 2'b10 subtracts the combined value from it, and 2'b11 reads it. Selector 0 or 1 picks the lane's first or second accumulator, and only that accumulator changes.
- R6: A read (2'b11) leaves the accumulator unchanged. For every opcode, the lane result is the selected accumulator's value after the operation.
- R7: The result equals the 40-bit accumulator value shifted arithmetically right by `shamt` bits. If the shifted value is above 32767 the result is 32767, and if it is below -32768 the result is -32768.
- R8: Accumulator add and subtract wrap modulo 2^40, with no saturation inside the accumulator.
- R9: Operations issued on consecutive cycles to the same accumulator each see the result of the one before, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Starts an operation this cycle |
| conj | input | 1 | 1 selects the conjugate product conj(a)·b |
| op_re | input | 2 | Opcode for the real lane |
| sel_re | input | 1 | Accumulator select for the real lane |
| op_im | input | 2 | Opcode for the imaginary lane |
| sel_im | input | 1 | Accumulator select for the imaginary lane |
| shamt | input | 6 | Arithmetic right shift applied before saturation |
| a | input | 32 | Operand a, {imag, real} |
| b | input | 32 | Operand b, {imag, real} |
| res_valid | output | 1 | Result ports hold the result of the operation issued two cycles earlier |
| res_re | output | 16 | Saturated result of the real lane |
| res_im | output | 16 | Saturated result of the imaginary lane |

## Verification
The product is swept over every pairing of eight boundary values in all four operand halves, in both plain and conjugate mode. This covers the most negative value, -1, 0, 1 and full scale. The sweep separates a swapped half or a wrong sign on either cross term, and it alternates the shift so that both exact and clamped outputs appear. A pseudo-random stream of mixed opcodes, selectors and shifts is then compared against a bench model of all four accumulators. It exposes a write to the wrong accumulator, a destructive read or a swapped add/subtract. Directed runs cover the clamp thresholds, hundreds of full-scale additions that cross 2^39, and back-to-back operations on one accumulator, which would reveal a stale read.

// File: rtl/cmac_pkg.sv
// Shared definitions for the dual-lane complex multiply-accumulate unit.
// Assumes: opcode values are part of the port contract and must not be reordered.
package cmac_pkg;

    // Per-lane operation code carried with every issued operation.
    typedef enum logic [1:0] {
        OPC_LOAD = 2'b00,   // clear selected accumulator, load combined value
        OPC_ADD  = 2'b01,   // accumulator += combined value
        OPC_SUB  = 2'b10,   // accumulator -= combined value
        OPC_READ = 2'b11    // no update, read out only
    } opc_e;

endpackage

// File: rtl/cmac_mult_stage.sv
// First pipeline stage of a lane: two signed multiplications, registered
// together with the control that travels alongside them.
// Assumes: operands are signed two's complement; control is captured only on issue.
module cmac_mult_stage #(
    parameter int IN_W = 16,
    parameter int SHW  = 6,
    localparam int PROD_W = 2 * IN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic signed [IN_W-1:0]   x0,
    input  logic signed [IN_W-1:0]   y0,
    input  logic signed [IN_W-1:0]   x1,
    input  logic signed [IN_W-1:0]   y1,
    input  logic                     sub_in,
    input  cmac_pkg::opc_e           op_in,
    input  logic                     sel_in,
    input  logic [SHW-1:0]           shamt_in,
    output logic signed [PROD_W-1:0] p0,
    output logic signed [PROD_W-1:0] p1,
    output logic                     sub_q,
    output cmac_pkg::opc_e           op_q,
    output logic                     sel_q,
    output logic [SHW-1:0]           shamt_q
);

    // Capture both products and the operation's control on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0      <= '0;
            p1      <= '0;
            sub_q   <= 1'b0;
            op_q    <= cmac_pkg::OPC_READ;
            sel_q   <= 1'b0;
            shamt_q <= '0;
        end else if (issue) begin
            p0      <= x0 * y0;
            p1      <= x1 * y1;
            sub_q   <= sub_in;
            op_q    <= op_in;
            sel_q   <= sel_in;
            shamt_q <= shamt_in;
        end
    end

endmodule

// File: rtl/cmac_sat_shift.sv
// Combinational readout path: arithmetic right shift of an accumulator
// value followed by clamping to a signed OUT_W-bit range.
// Assumes: ACC_W > OUT_W; shift amounts beyond ACC_W-1 give pure sign fill.
module cmac_sat_shift #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16,
    parameter int SHW   = 6
) (
    input  logic signed [ACC_W-1:0] val,
    input  logic [SHW-1:0]          shamt,
    output logic [OUT_W-1:0]        res
);

    localparam logic signed [ACC_W-1:0] HI_LIM =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO_LIM =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] shifted;

    // Shift, then clamp anything outside the signed output range.
    always_comb begin
        shifted = val >>> shamt;
        if (shifted > HI_LIM)
            res = HI_LIM[OUT_W-1:0];
        else if (shifted < LO_LIM)
            res = LO_LIM[OUT_W-1:0];
        else
            res = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/cmac_acc_bank.sv
// Second pipeline stage of a lane: combines the two products, updates the
// selected accumulator in place, and registers the saturated view of the
// accumulator after the operation.
// Assumes: source and destination accumulator are always the same one;
// arithmetic inside the accumulator wraps modulo 2**ACC_W.
module cmac_acc_bank #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 40,
    parameter int SHW   = 6,
    parameter int N_ACC = 2,
    localparam int PROD_W = 2 * IN_W,
    localparam int SUM_W  = PROD_W + 1,
    localparam int SELW   = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic signed [PROD_W-1:0] p0,
    input  logic signed [PROD_W-1:0] p1,
    input  logic                     sub,
    input  cmac_pkg::opc_e           op,
    input  logic [SELW-1:0]          sel,
    input  logic [SHW-1:0]           shamt,
    output logic [IN_W-1:0]          res
);

    logic signed [ACC_W-1:0] acc_q [N_ACC];
    logic signed [SUM_W-1:0] comb_val;
    logic signed [ACC_W-1:0] comb_ext;
    logic signed [ACC_W-1:0] cur_val;
    logic signed [ACC_W-1:0] nxt_val;
    logic [IN_W-1:0]         sat_val;

    // Product combination and next accumulator value for the chosen opcode.
    always_comb begin
        comb_val = sub ? (SUM_W'(p0) - SUM_W'(p1)) : (SUM_W'(p0) + SUM_W'(p1));
        comb_ext = {{(ACC_W-SUM_W){comb_val[SUM_W-1]}}, comb_val};
        cur_val  = acc_q[sel];
        unique case (op)
            cmac_pkg::OPC_LOAD: nxt_val = comb_ext;
            cmac_pkg::OPC_ADD:  nxt_val = cur_val + comb_ext;
            cmac_pkg::OPC_SUB:  nxt_val = cur_val - comb_ext;
            default:            nxt_val = cur_val;
        endcase
    end

    // One register per accumulator, written only when selected and not reading.
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (vld && (op != cmac_pkg::OPC_READ) && (sel == SELW'(g)))
                acc_q[g] <= nxt_val;
        end
    end

    cmac_sat_shift #(
        .ACC_W (ACC_W),
        .OUT_W (IN_W),
        .SHW   (SHW)
    ) u_sat (
        .val   (nxt_val),
        .shamt (shamt),
        .res   (sat_val)
    );

    // Hold the saturated post-operation view until the next valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (vld)
            res <= sat_val;
    end

endmodule

// File: rtl/cmac_lane.sv
// One arithmetic lane: multiply stage followed by accumulate/readout stage.
// Assumes: the caller routes operand halves so this lane sees the pairs it
// must multiply, and supplies the stage-1 valid flag.
module cmac_lane #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 40,
    parameter int SHW   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic                   s1_vld,
    input  logic signed [IN_W-1:0] x0,
    input  logic signed [IN_W-1:0] y0,
    input  logic signed [IN_W-1:0] x1,
    input  logic signed [IN_W-1:0] y1,
    input  logic                   sub,
    input  logic [1:0]             op,
    input  logic                   sel,
    input  logic [SHW-1:0]         shamt,
    output logic [IN_W-1:0]        res
);

    localparam int PROD_W = 2 * IN_W;

    logic signed [PROD_W-1:0] p0_q, p1_q;
    logic                     sub_q, sel_q;
    cmac_pkg::opc_e           op_q;
    logic [SHW-1:0]           shamt_q;

    cmac_mult_stage #(
        .IN_W (IN_W),
        .SHW  (SHW)
    ) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .x0       (x0),
        .y0       (y0),
        .x1       (x1),
        .y1       (y1),
        .sub_in   (sub),
        .op_in    (cmac_pkg::opc_e'(op)),
        .sel_in   (sel),
        .shamt_in (shamt),
        .p0       (p0_q),
        .p1       (p1_q),
        .sub_q    (sub_q),
        .op_q     (op_q),
        .sel_q    (sel_q),
        .shamt_q  (shamt_q)
    );

    cmac_acc_bank #(
        .IN_W  (IN_W),
        .ACC_W (ACC_W),
        .SHW   (SHW),
        .N_ACC (2)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (s1_vld),
        .p0    (p0_q),
        .p1    (p1_q),
        .sub   (sub_q),
        .op    (op_q),
        .sel   (sel_q),
        .shamt (shamt_q),
        .res   (res)
    );

endmodule

// File: rtl/cmac_pair.sv
// Dual-lane complex multiply-accumulate unit. Lane 0 produces the real part
// and lane 1 the imaginary part, so one complex (or conjugate) product
// completes per cycle. Results appear two cycles after issue.
// Assumes: operand words are {imag, real}; per-lane opcode and accumulator
// select are independent; one shift amount serves both lanes.
module cmac_pair #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 40,
    parameter int SHW   = $clog2(ACC_W),
    localparam int WORD_W = 2 * IN_W,
    localparam int N_LANE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              conj,
    input  logic [1:0]        op_re,
    input  logic              sel_re,
    input  logic [1:0]        op_im,
    input  logic              sel_im,
    input  logic [SHW-1:0]    shamt,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              res_valid,
    output logic [IN_W-1:0]   res_re,
    output logic [IN_W-1:0]   res_im
);

    logic signed [IN_W-1:0] a_re, a_im, b_re, b_im;
    logic                   s1_vld_q, s2_vld_q;
    logic [IN_W-1:0]        lane_res [N_LANE];

    assign a_re = a[IN_W-1:0];
    assign a_im = a[WORD_W-1:IN_W];
    assign b_re = b[IN_W-1:0];
    assign b_im = b[WORD_W-1:IN_W];

    // Valid flag travels alongside the two datapath stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld_q <= 1'b0;
            s2_vld_q <= 1'b0;
        end else begin
            s1_vld_q <= issue;
            s2_vld_q <= s1_vld_q;
        end
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        logic signed [IN_W-1:0] x0, y0, x1, y1;
        logic                   sub;
        logic [1:0]             op;
        logic                   sel;

        if (g == 0) begin : g_real
            // Real part: ar*br -+ ai*bi, subtract unless conjugating.
            assign x0  = a_re;
            assign y0  = b_re;
            assign x1  = a_im;
            assign y1  = b_im;
            assign sub = ~conj;
            assign op  = op_re;
            assign sel = sel_re;
        end else begin : g_imag
            // Imaginary part: ar*bi +- ai*br, subtract only when conjugating.
            assign x0  = a_re;
            assign y0  = b_im;
            assign x1  = a_im;
            assign y1  = b_re;
            assign sub = conj;
            assign op  = op_im;
            assign sel = sel_im;
        end

        cmac_lane #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W),
            .SHW   (SHW)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (issue),
            .s1_vld (s1_vld_q),
            .x0     (x0),
            .y0     (y0),
            .x1     (x1),
            .y1     (y1),
            .sub    (sub),
            .op     (op),
            .sel    (sel),
            .shamt  (shamt),
            .res    (lane_res[g])
        );
    end

    assign res_valid = s2_vld_q;
    assign res_re    = lane_res[0];
    assign res_im    = lane_res[1];

endmodule

// File: rtl/cmac_pair_chk.sv
// Property checker for cmac_pair, attached with bind. It tracks issued
// operations through its own two-stage shadow pipeline and relates the
// result ports to them.
// Assumes: the same parameters as the bound instance.
module cmac_pair_chk #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 40,
    parameter int SHW   = 6,
    localparam int WORD_W = 2 * IN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic              conj,
    input logic [1:0]        op_re,
    input logic              sel_re,
    input logic [1:0]        op_im,
    input logic              sel_im,
    input logic [SHW-1:0]    shamt,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic              res_valid,
    input logic [IN_W-1:0]   res_re,
    input logic [IN_W-1:0]   res_im
);

    localparam logic [WORD_W-1:0] UNIT_B = WORD_W'(1);
    localparam int KEY_W = SHW + 2;

    logic              iss1, iss2;
    logic              unit1, unit2;
    logic              cself1, cself2;
    logic              rd1, rd2, rd3;
    logic [KEY_W-1:0]  key1, key2, key3;
    logic [WORD_W-1:0] a1, a2;
    logic              unit_now, cself_now, rd_now;

    assign unit_now  = issue && !conj && (op_re == 2'b00) && (op_im == 2'b00)
                       && (b == UNIT_B) && (shamt == '0);
    assign cself_now = issue && conj && (op_im == 2'b00) && (a == b) && (shamt == '0);
    assign rd_now    = issue && (op_re == 2'b11) && (op_im == 2'b11);

    // Shadow pipeline of issued operations and their attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss1 <= 1'b0; iss2 <= 1'b0;
            unit1 <= 1'b0; unit2 <= 1'b0;
            cself1 <= 1'b0; cself2 <= 1'b0;
            rd1 <= 1'b0; rd2 <= 1'b0; rd3 <= 1'b0;
            key1 <= '0; key2 <= '0; key3 <= '0;
            a1 <= '0; a2 <= '0;
        end else begin
            iss1 <= issue;      iss2 <= iss1;
            unit1 <= unit_now;  unit2 <= unit1;
            cself1 <= cself_now; cself2 <= cself1;
            rd1 <= rd_now;      rd2 <= rd1;      rd3 <= rd2;
            key1 <= {sel_re, sel_im, shamt}; key2 <= key1; key3 <= key2;
            a1 <= a;            a2 <= a1;
        end
    end

    // R1: no result is flagged in the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !res_valid);

    // R4: a result is flagged exactly two cycles after each issue.
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == iss2);

    // R2: loading a times (1 + 0j) with no shift returns a unchanged.
    a_r2_unit_product: assert property (@(posedge clk) disable iff (!rst_n)
        unit2 |-> (res_re == a2[IN_W-1:0]) && (res_im == a2[WORD_W-1:IN_W]));

    // R3: the conjugate product of a value with itself has zero imaginary part.
    a_r3_conj_self_imag: assert property (@(posedge clk) disable iff (!rst_n)
        cself2 |-> (res_im == '0));

    // R6: two back-to-back identical reads return identical results.
    a_r6_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd2 && rd3 && (key2 == key3)) |-> ($stable(res_re) && $stable(res_im)));

endmodule

bind cmac_pair cmac_pair_chk #(
    .IN_W  (IN_W),
    .ACC_W (ACC_W),
    .SHW   (SHW)
) u_chk (.*);

// File: tb/sim_cmac_pair.sv
// Self-checking bench for cmac_pair: exhaustive boundary-value product
// sweeps, a pseudo-random accumulate stream against a bench model,
// and directed clamp, wrap and back-to-back runs.
module sim_cmac_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic        conj = 1'b0;
    logic [1:0]  op_re = 2'b11, op_im = 2'b11;
    logic        sel_re = 1'b0, sel_im = 1'b0;
    logic [5:0]  shamt = '0;
    logic [31:0] a = '0, b = '0;
    logic        res_valid;
    logic [15:0] res_re, res_im;

    int n_chk = 0;
    int n_err = 0;
    logic signed [39:0] m_acc [4];
    logic [31:0] rng = 32'h1234_5678;

    cmac_pair u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .conj(conj),
        .op_re(op_re), .sel_re(sel_re), .op_im(op_im), .sel_im(sel_im),
        .shamt(shamt), .a(a), .b(b),
        .res_valid(res_valid), .res_re(res_re), .res_im(res_im)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [31:0] next_rng(logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Combined value of a lane, from the product formulas.
    function automatic logic signed [39:0] lane_val(int lane, logic [31:0] av,
                                                    logic [31:0] bv, logic cj);
        longint ar, ai, br, bi, r;
        ar = longint'($signed(av[15:0]));
        ai = longint'($signed(av[31:16]));
        br = longint'($signed(bv[15:0]));
        bi = longint'($signed(bv[31:16]));
        if (lane == 0) r = cj ? (ar*br + ai*bi) : (ar*br - ai*bi);
        else           r = cj ? (ar*bi - ai*br) : (ar*bi + ai*br);
        return r[39:0];
    endfunction

    function automatic logic [15:0] sat_view(logic signed [39:0] v, int sh);
        longint x;
        x = longint'(v) >>> sh;
        if (x > 32767)  return 16'h7fff;
        if (x < -32768) return 16'h8000;
        return x[15:0];
    endfunction

    function automatic logic signed [39:0] apply_op(logic signed [39:0] cur,
                                                    logic [1:0] op,
                                                    logic signed [39:0] v);
        case (op)
            2'b00:   return v;
            2'b01:   return cur + v;
            2'b10:   return cur - v;
            default: return cur;
        endcase
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Update the bench model for one operation and return both expected results.
    task automatic model_op(logic [1:0] opr, logic slr, logic [1:0] opi, logic sli,
                            logic [31:0] av, logic [31:0] bv, logic cj, int sh,
                            output logic [15:0] er, output logic [15:0] ei);
        int ir, ii;
        ir = slr ? 1 : 0;
        ii = sli ? 3 : 2;
        m_acc[ir] = apply_op(m_acc[ir], opr, lane_val(0, av, bv, cj));
        m_acc[ii] = apply_op(m_acc[ii], opi, lane_val(1, av, bv, cj));
        er = sat_view(m_acc[ir], sh);
        ei = sat_view(m_acc[ii], sh);
    endtask

    // Issue one operation at a falling edge and check its result two cycles later.
    task automatic do_op(string tag, logic [1:0] opr, logic slr, logic [1:0] opi,
                         logic sli, logic [31:0] av, logic [31:0] bv, logic cj, int sh);
        logic [15:0] er, ei;
        model_op(opr, slr, opi, sli, av, bv, cj, sh, er, ei);
        @(negedge clk);
        op_re = opr; sel_re = slr; op_im = opi; sel_im = sli;
        a = av; b = bv; conj = cj; shamt = 6'(sh); issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check("R4", "valid one cycle after issue", longint'(res_valid), 0);
        @(negedge clk);
        check("R4", "valid two cycles after issue", longint'(res_valid), 1);
        check(tag, "real result", longint'($signed(res_re)), longint'($signed(er)));
        check(tag, "imag result", longint'($signed(res_im)), longint'($signed(ei)));
    endtask

    initial begin
        logic [15:0] vals [8];
        logic [15:0] pr [8];
        logic [15:0] pi [8];
        int k;
        vals[0] = 16'h8000; vals[1] = 16'hffff; vals[2] = 16'h0000; vals[3] = 16'h0001;
        vals[4] = 16'h0002; vals[5] = 16'h3039; vals[6] = 16'h7fff; vals[7] = 16'hb1e0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1", "valid during reset", longint'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", longint'(res_valid), 0);
        do_op("R1", 2'b11, 1'b0, 2'b11, 1'b0, 32'h0, 32'h0, 1'b0, 0);
        do_op("R1", 2'b11, 1'b1, 2'b11, 1'b1, 32'h0, 32'h0, 1'b0, 0);

        // R2 / R3: boundary-value sweep of plain and conjugate products.
        k = 0;
        for (int cj = 0; cj < 2; cj++)
            for (int i0 = 0; i0 < 8; i0++)
                for (int i1 = 0; i1 < 8; i1++)
                    for (int i2 = 0; i2 < 8; i2++)
                        for (int i3 = 0; i3 < 8; i3++) begin
                            k++;
                            do_op(cj ? "R3" : "R2", 2'b00, 1'(k % 2), 2'b00, 1'(k % 2),
                                  {vals[i1], vals[i0]}, {vals[i3], vals[i2]},
                                  1'(cj), (k % 3 == 0) ? 0 : 16);
                        end

        // R7: clamp thresholds.
        do_op("R7", 2'b00, 1'b0, 2'b00, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 0);
        do_op("R7", 2'b00, 1'b0, 2'b00, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 15);
        do_op("R7", 2'b00, 1'b0, 2'b00, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 16);
        do_op("R7", 2'b00, 1'b1, 2'b00, 1'b1, 32'h0000_7fff, 32'h0000_8000, 1'b0, 0);
        do_op("R7", 2'b00, 1'b1, 2'b00, 1'b1, 32'h0000_7fff, 32'h0000_8000, 1'b0, 15);
        do_op("R7", 2'b00, 1'b1, 2'b00, 1'b1, 32'h0001_0000, 32'h0000_7fff, 1'b0, 0);
        do_op("R7", 2'b00, 1'b1, 2'b00, 1'b1, 32'h0001_0000, 32'h0000_8000, 1'b0, 0);

        // R5 / R6: pseudo-random opcode stream against the model.
        for (int n = 0; n < 800; n++) begin
            logic [31:0] r1, r2, r3;
            rng = next_rng(rng); r1 = rng;
            rng = next_rng(rng); r2 = rng;
            rng = next_rng(rng); r3 = rng;
            do_op((r3[1:0] == 2'b11) ? "R6" : "R5", r3[1:0], r3[2], r3[4:3], r3[5],
                  r1, r2, r3[6], int'(r3[12:8]) % 40);
        end

        // R9: consecutive issues hit the same accumulators without stall.
        begin
            logic [15:0] qr [8];
            logic [15:0] qi [8];
            logic [1:0]  ops [8];
            for (int n = 0; n < 8; n++) ops[n] = (n % 4 == 3) ? 2'b11 : ((n == 0) ? 2'b00 : 2'b01);
            for (int n = 0; n < 10; n++) begin
                @(negedge clk);
                if (n >= 2) begin
                    check("R9", "valid in stream", longint'(res_valid), 1);
                    check("R9", "real in stream", longint'($signed(res_re)), longint'($signed(qr[n-2])));
                    check("R9", "imag in stream", longint'($signed(res_im)), longint'($signed(qi[n-2])));
                end
                if (n < 8) begin
                    model_op(ops[n], 1'b0, ops[n], 1'b1, 32'h0123_0456 + 32'(n),
                             32'hfedc_0789, 1'(n % 2), 4, qr[n], qi[n]);
                    op_re = ops[n]; sel_re = 1'b0; op_im = ops[n]; sel_im = 1'b1;
                    a = 32'h0123_0456 + 32'(n); b = 32'hfedc_0789;
                    conj = 1'(n % 2); shamt = 6'd4; issue = 1'b1;
                end else begin
                    issue = 1'b0;
                end
            end
        end

        // R8: repeated full-scale additions cross 2^39 and wrap.
        do_op("R8", 2'b00, 1'b1, 2'b00, 1'b0, 32'h0, 32'h0, 1'b0, 24);
        for (int n = 0; n < 300; n++)
            do_op("R8", 2'b01, 1'b1, 2'b10, 1'b0, 32'h7fff_8000, 32'h8000_8000, 1'b0, 24);
        do_op("R8", 2'b11, 1'b1, 2'b11, 1'b0, 32'h0, 32'h0, 1'b0, 39);

        // R5: final readout of all four accumulators.
        do_op("R5", 2'b11, 1'b0, 2'b11, 1'b0, 32'h0, 32'h0, 1'b0, 8);
        do_op("R5", 2'b11, 1'b1, 2'b11, 1'b1, 32'h0, 32'h0, 1'b0, 8);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule